// File: doc/BRIEF.md
# I/O Bridge Retry Responder

This block lives in the I/O bridge of a shared system bus. It serves reads aimed at slow registers that sit behind a remote I/O bus. A remote register read can take several microseconds, which is far more than one bus cycle. Holding the system bus for that long would stop every other node, so the bridge does not stall. It replies at once with a retry. The requester gives up the bus and later issues the same read again. Until then, other nodes keep the system bus for their own traffic, such as memory accesses.

The block has one pending slot. The first read to reach an empty slot records its requester ID and address, starts the remote access through a simple request/acknowledge port, and gets a retry. Every later read gets a retry until the remote data has arrived. From then on, only a reissue whose ID and address both match the recorded ones completes, and it receives the data. That completion empties the slot. A programmable timeout ends a remote access that is never acknowledged. The owner's next matching reissue then receives an error response, so no requester retries forever.

Top module: `io_retry_resp`

## Requirements
- R1: Each cycle with `cmd_valid` high produces exactly one response on the next cycle. `rsp_valid` is high for one cycle, and `rsp_id` carries that command's ID. `rsp_kind` encodes 2'b01 = data, 2'b10 = retry, 2'b11 = error.
- R2: A command that finds the slot empty gets a retry. It records its ID and address. `rmt_req` is raised on the next cycle with `rmt_addr` equal to the recorded address, and it stays high until `rmt_ack` or a timeout.
- R3: While the remote access is outstanding, every command gets a retry. No new remote access starts, and the recorded ID and address do not change.
- R4: After `rmt_ack`, the slot holds `rmt_data`. A command whose ID and address both match the recorded pair gets a data response carrying that value. The slot is then empty, so the next command starts a new remote access.
- R5: While data is held, a command that differs in ID or in address gets a retry. The held data stays for the owner.
- R6: With `tmo_limit` = N > 0, an access that sees no acknowledge during N cycles of `rmt_req` ends: `rmt_req` falls after exactly N cycles high. The owner's matching reissue then gets an error response with data 0 and frees the slot. With `tmo_limit` = 0, no timeout occurs.
- R7: Reset leaves `rsp_valid` and `rmt_req` low and the slot empty.
- R8: An `rmt_ack` that arrives while no remote access is outstanding has no effect on the held data or on the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command present this cycle |
| cmd_id | input | ID_W | Requester ID of the command |
| cmd_addr | input | ADDR_W | Register address of the command |
| tmo_limit | input | TMO_W | Remote timeout in cycles, 0 disables it |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 01 data, 10 retry, 11 error |
| rsp_id | output | ID_W | Requester ID the response is for |
| rsp_data | output | DATA_W | Read data, 0 unless kind is data |
| rmt_req | output | 1 | Remote access request, held until acknowledge |
| rmt_addr | output | ADDR_W | Remote access address |
| rmt_ack | input | 1 | Remote access done, data valid |
| rmt_data | input | DATA_W | Remote read data |

## Verification
The bench sends reissues that match on only one of the two fields. A design that compared only the ID or only the address would hand the held data to a stranger, and the owner would then retry forever. It fires commands from other requesters while the remote side is busy. A design that re-captured on each command would move `rmt_addr` or start a second access. It times the exact cycle on which `rmt_req` falls for a small timeout, so an off-by-one counter is caught. It also checks that a zero limit never ends the access. Stray acknowledges while idle or holding data are injected, and a design that let them overwrite the slot would return the wrong value.

// File: rtl/io_rr_pkg.sv
package io_rr_pkg;
  typedef enum logic [1:0] {
    SL_IDLE = 2'd0,
    SL_BUSY = 2'd1,
    SL_DATA = 2'd2,
    SL_ERR  = 2'd3
  } slot_st_t;

  typedef enum logic [1:0] {
    RK_NONE  = 2'b00,
    RK_DATA  = 2'b01,
    RK_RETRY = 2'b10,
    RK_ERR   = 2'b11
  } rsp_kind_t;
endpackage

// File: rtl/io_rr_slot.sv
module io_rr_slot
  import io_rr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              rmt_ack,
  input  logic [DATA_W-1:0] rmt_data,
  input  logic              tmo_fire,
  output slot_st_t          st,
  output logic [ID_W-1:0]   pend_id,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic              ev_start,
  output logic              ev_hit,
  output logic              ev_fill
);
  function automatic logic owns_slot(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                                     input logic [ID_W-1:0] pid, input logic [ADDR_W-1:0] paddr);
    return (id == pid) && (addr == paddr);
  endfunction

  logic holding;
  assign holding  = (st == SL_DATA) || (st == SL_ERR);
  assign ev_start = cmd_valid && (st == SL_IDLE);
  assign ev_hit   = cmd_valid && holding && owns_slot(cmd_id, cmd_addr, pend_id, pend_addr);
  assign ev_fill  = (st == SL_BUSY) && rmt_ack;

  slot_st_t st_nx;
  always_comb begin
    st_nx = st;
    unique case (st)
      SL_IDLE: if (ev_start) st_nx = SL_BUSY;
      SL_BUSY: begin
        if (ev_fill)       st_nx = SL_DATA;
        else if (tmo_fire) st_nx = SL_ERR;
      end
      default: if (ev_hit) st_nx = SL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SL_IDLE;
      pend_id   <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      st <= st_nx;
      if (ev_start) begin
        pend_id   <= cmd_id;
        pend_addr <= cmd_addr;
      end
      if (ev_fill)
        pend_data <= rmt_data;
      else if ((st == SL_BUSY) && tmo_fire)
        pend_data <= '0;
    end
  end

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SL_IDLE && cmd_valid) |=> ($stable(pend_id) && $stable(pend_addr))); // R3
  AST_FREE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (st == SL_IDLE)); // R4
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SL_BUSY && !ev_start && !ev_hit) |=> ($stable(st) && $stable(pend_data))); // R8
endmodule

// File: rtl/io_rr_timer.sv
module io_rr_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             ack,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_fire
);
  logic [TMO_W-1:0] cnt;

  function automatic logic limit_reached(input logic [TMO_W-1:0] c, input logic [TMO_W-1:0] lim);
    return (lim != '0) && (c == lim - 1'b1);
  endfunction

  assign tmo_fire = busy && !ack && limit_reached(cnt, limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || ack) cnt <= '0;
    else if (!tmo_fire)         cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && limit != '0 && $stable(limit)) |-> (cnt < limit)); // R6
endmodule

// File: rtl/io_rr_resp.sv
module io_rr_resp
  import io_rr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic              ev_hit,
  input  slot_st_t          st,
  input  logic [DATA_W-1:0] pend_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data
);
  function automatic rsp_kind_t pick_kind(input logic hit, input slot_st_t s);
    if (!hit)           return RK_RETRY;
    else if (s == SL_ERR) return RK_ERR;
    else                return RK_DATA;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RK_NONE;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_kind  <= cmd_valid ? pick_kind(ev_hit, st) : RK_NONE;
      rsp_id    <= cmd_valid ? cmd_id : '0;
      rsp_data  <= (cmd_valid && ev_hit && st == SL_DATA) ? pend_data : '0;
    end
  end

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (rsp_valid && rsp_id == $past(cmd_id))); // R1
  AST_BUSY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SL_BUSY && cmd_valid) |=> (rsp_kind == RK_RETRY)); // R3
endmodule

// File: rtl/io_retry_resp.sv
module io_retry_resp
  import io_rr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rmt_req,
  output logic [ADDR_W-1:0] rmt_addr,
  input  logic              rmt_ack,
  input  logic [DATA_W-1:0] rmt_data
);
  slot_st_t          slot_st;
  logic [ID_W-1:0]   pend_id;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              ev_start, ev_hit, ev_fill, tmo_fire;

  io_rr_slot #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_addr(cmd_addr),
    .rmt_ack(rmt_ack), .rmt_data(rmt_data), .tmo_fire(tmo_fire), .st(slot_st),
    .pend_id(pend_id), .pend_addr(pend_addr), .pend_data(pend_data),
    .ev_start(ev_start), .ev_hit(ev_hit), .ev_fill(ev_fill)
  );

  io_rr_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .busy(slot_st == SL_BUSY), .ack(rmt_ack),
    .limit(tmo_limit), .tmo_fire(tmo_fire)
  );

  io_rr_resp #(.ID_W(ID_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_id(cmd_id), .ev_hit(ev_hit),
    .st(slot_st), .pend_data(pend_data), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  assign rmt_req  = (slot_st == SL_BUSY);
  assign rmt_addr = pend_addr;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_req && !rmt_ack && !tmo_fire) |=> (rmt_req && $stable(rmt_addr))); // R2
  AST_TMO_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (!rmt_req && slot_st == SL_ERR)); // R6
  AST_FILL_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> !rmt_req); // R4
  AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (rmt_req && rmt_addr == $past(cmd_addr))); // R2
endmodule

// File: tb/io_retry_resp_tb.sv
module io_retry_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 32, TMO_W = 16;
  localparam logic [1:0] K_DATA = 2'b01, K_RETRY = 2'b10, K_ERR = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [ID_W-1:0] cmd_id = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic rsp_valid, rmt_req;
  logic [1:0] rsp_kind;
  logic [ID_W-1:0] rsp_id;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] rmt_addr;
  logic rmt_ack = 1'b0;
  logic [DATA_W-1:0] rmt_data = '0;

  int checks = 0, errors = 0;
  logic [1:0] g_kind;
  logic [DATA_W-1:0] g_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_retry_resp #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_addr(cmd_addr),
    .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .rmt_req(rmt_req), .rmt_addr(rmt_addr), .rmt_ack(rmt_ack),
    .rmt_data(rmt_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one command at a negedge, sample the reply at the next negedge.
  task automatic send(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_id = id; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 valid", rsp_valid, 1'b1);
    chk("R1 id", rsp_id, id);
    g_kind = rsp_kind; g_data = rsp_data;
    @(negedge clk);
    chk("R1 single", rsp_valid, 1'b0);
  endtask

  task automatic ack(input logic [DATA_W-1:0] d);
    @(negedge clk);
    rmt_ack = 1'b1; rmt_data = d;
    @(negedge clk);
    rmt_ack = 1'b0; rmt_data = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 rsp_valid", rsp_valid, 1'b0);
    chk("R7 rmt_req", rmt_req, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic;
    tmo_limit = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_id = 4'h3; cmd_addr = 16'h0120;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 first gets retry", rsp_kind, K_RETRY);
    chk("R2 req raised", rmt_req, 1'b1);
    chk("R2 req addr", rmt_addr, 16'h0120);
    repeat (3) @(negedge clk);
    chk("R2 req held", rmt_req, 1'b1);
    ack(32'hCAFE_0001);
    chk("R4 req dropped", rmt_req, 1'b0);
    send(4'h3, 16'h0120);
    chk("R4 kind data", g_kind, K_DATA);
    chk("R4 data", g_data, 32'hCAFE_0001);
    send(4'h3, 16'h0120);
    chk("R4 slot freed new retry", g_kind, K_RETRY);
    chk("R4 new access", rmt_req, 1'b1);
    ack(32'h1111_2222);
    send(4'h3, 16'h0120);
    chk("R4 second data", g_data, 32'h1111_2222);
  endtask

  task automatic t_busy;
    send(4'h5, 16'h0200);
    chk("R2 retry", g_kind, K_RETRY);
    send(4'h6, 16'h0300);
    chk("R3 other gets retry", g_kind, K_RETRY);
    chk("R3 addr unchanged", rmt_addr, 16'h0200);
    send(4'h5, 16'h0200);
    chk("R3 owner still retry", g_kind, K_RETRY);
    chk("R3 req still on", rmt_req, 1'b1);
    ack(32'h0000_BEEF);
    send(4'h6, 16'h0300);
    chk("R3 intruder no data", g_kind, K_RETRY);
    send(4'h5, 16'h0200);
    chk("R3 owner data", g_data, 32'h0000_BEEF);
  endtask

  task automatic t_mismatch;
    send(4'h9, 16'h0440);
    ack(32'h5A5A_5A5A);
    send(4'hA, 16'h0440);
    chk("R5 id mismatch retry", g_kind, K_RETRY);
    chk("R5 no new req", rmt_req, 1'b0);
    send(4'h9, 16'h0444);
    chk("R5 addr mismatch retry", g_kind, K_RETRY);
    send(4'h9, 16'h0440);
    chk("R5 owner data kind", g_kind, K_DATA);
    chk("R5 data kept", g_data, 32'h5A5A_5A5A);
  endtask

  task automatic t_timeout;
    tmo_limit = 16'd5;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_id = 4'h2; cmd_addr = 16'h0800;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 req on", rmt_req, 1'b1);
    repeat (4) @(negedge clk);
    chk("R6 req held to limit", rmt_req, 1'b1);
    @(negedge clk);
    chk("R6 req dropped at limit", rmt_req, 1'b0);
    send(4'h7, 16'h0800);
    chk("R6 other retry", g_kind, K_RETRY);
    send(4'h2, 16'h0800);
    chk("R6 error kind", g_kind, K_ERR);
    chk("R6 error data zero", g_data, 32'h0);
    send(4'h2, 16'h0800);
    chk("R6 freed after error", g_kind, K_RETRY);
    tmo_limit = '0;
    repeat (30) @(negedge clk);
    chk("R6 zero limit no timeout", rmt_req, 1'b1);
    ack(32'h0BAD_F00D);
    send(4'h2, 16'h0800);
    chk("R6 late ack data", g_data, 32'h0BAD_F00D);
  endtask

  task automatic t_stray;
    ack(32'hDEAD_0000);
    chk("R8 idle ack no req", rmt_req, 1'b0);
    send(4'h1, 16'h0010);
    chk("R8 idle ack retry", g_kind, K_RETRY);
    ack(32'h0000_0042);
    ack(32'hDEAD_0001);
    send(4'h1, 16'h0010);
    chk("R8 held data kept", g_data, 32'h0000_0042);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_busy();
    t_mismatch();
    t_timeout();
    t_stray();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule